// File: doc/BRIEF.md
# Periodic Interrupt Timer

A down-counting timer that raises a periodic interrupt request, programmed through a small register interface. Software writes a 16-bit modulus. Each write loads the counter at once. While the run bit is set, the counter steps down by one on every cycle in which the single-cycle tick input is high. A tick that finds the counter at zero reloads it from the modulus and raises a sticky status flag. The period is therefore modulus + 1 ticks.

The flag stays set until software writes a one to its bit; writing zero there has no effect. While the flag and the interrupt enable are both set, the block drives a request on one of eight level lines. A one-hot level field in the control/status register selects the line. A debug freeze input halts counting, but only when the freeze-control bit is set. It has no effect when that bit is clear, which is the reset state.

Top module: `pit_timer`

## Requirements
- R1: After reset all control bits, the level field and the flag read 0, the modulus and counter read 0xFFFF, and every `irq_o` line is 0.
- R2: On a cycle where the run bit (control/status bit 8) is 1 and `tick_i` is 1, a nonzero counter decrements by one. With the run bit 0 or `tick_i` 0, the counter holds.
- R3: A counting tick that finds the counter at 0 reloads it from the modulus and sets the flag (control/status bit 15) on the same edge, giving a period of modulus + 1 ticks.
- R4: A write with `sel_i` = 0 stores the modulus and loads the counter with the written value on the same edge, overriding any count step in that cycle.
- R5: A write with `sel_i` = 1 and data bit 15 = 1 clears the flag. Data bit 15 = 0 leaves it unchanged. A reload in the same cycle as a clearing write leaves the flag set.
- R6: The request is active only while both the flag and the interrupt enable (control/status bit 9) are 1, and it stays active until the flag is cleared.
- R7: With freeze control (control/status bit 10) at 1 and `freeze_i` high, ticks are ignored and the counter holds. With freeze control at 0, `freeze_i` has no effect.
- R8: Control/status bits 7:0 form the level field. Field bit 7-k routes the request to `irq_o[k]`, so 0x80 selects level 0 and 0x01 selects level 7.
- R9: `rdata_o` shows the modulus for `sel_i` = 0, the control/status register for 1 (bits 14:11 read 0), the counter for 2, and zero for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle timer tick enable |
| freeze_i | input | 1 | Debug freeze request |
| wr_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select: 0 modulus, 1 control/status, 2 counter, 3 none |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the selected register |
| irq_o | output | 8 | Request lines, bit k is level k |

## Verification
The assertions check on every cycle that the counter holds when not stepped and decrements or reloads when stepped. They also check that a modulus write loads the counter, that a frozen counter stays still, that the flag is sticky until cleared and set after a reload, and that no request line is active without the flag and enable. Some behaviour shows only in the bench scenarios: the exact period against a chosen modulus, a reload colliding with a clearing write, the level routing for particular field values, and the readback layout. The bench compares the ports every cycle against its own register model, under random writes, ticks and freeze.

// File: rtl/pit_pkg.sv
package pit_pkg;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned CNT_W  = 16;
  parameter int unsigned LVL_W  = 8;

  localparam int unsigned CS_RUN  = LVL_W;
  localparam int unsigned CS_IE   = LVL_W + 1;
  localparam int unsigned CS_FRZ  = LVL_W + 2;
  localparam int unsigned CS_FLAG = DATA_W - 1;
  localparam logic [CNT_W-1:0] CNT_RST = '1;

  typedef enum logic [1:0] {
    SEL_MOD  = 2'd0,
    SEL_CS   = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             run;
    logic             ie;
    logic             frz_en;
  } ctrl_t;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  mod_o,
  output logic              flag_o,
  output logic              mod_load_o
);
  logic cs_wr, flag_clr;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] mod_q;
  logic flag_q;

  assign cs_wr      = wr_i && (sel_e'(sel_i) == SEL_CS);
  assign mod_load_o = wr_i && (sel_e'(sel_i) == SEL_MOD);
  assign flag_clr   = cs_wr && wdata_i[CS_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mod_q  <= CNT_RST;
    end else begin
      if (cs_wr) begin
        ctrl_q.lvl    <= wdata_i[LVL_W-1:0];
        ctrl_q.run    <= wdata_i[CS_RUN];
        ctrl_q.ie     <= wdata_i[CS_IE];
        ctrl_q.frz_en <= wdata_i[CS_FRZ];
      end
      if (mod_load_o) mod_q <= wdata_i[CNT_W-1:0];
    end
  end

  // reload beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (wrap_i)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
  assign mod_o  = mod_q;
  assign flag_o = flag_q;

  a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !flag_clr |=> flag_q);
  a_r3_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_q);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr && !wrap_i |=> !flag_q);
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic at_zero;

  assign at_zero = (cnt_q == '0);
  assign wrap_o  = step_i && at_zero && !load_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)       cnt_d = load_val_i;
    else if (wrap_o)  cnt_d = mod_i;
    else if (step_i)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_RST;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_i |=> $stable(cnt_q));
  a_r2_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !at_zero |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && at_zero |=> cnt_q == $past(mod_i));
  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/pit_irq_map.sv
module pit_irq_map
  import pit_pkg::*;
(
  input  logic             req_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] irq_o
);
  // field MSB is level 0
  for (genvar k = 0; k < LVL_W; k++) begin : g_lvl
    assign irq_o[k] = req_i && lvl_i[LVL_W-1-k];
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              freeze_i,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  irq_o
);
  ctrl_t ctrl;
  logic [CNT_W-1:0] mod_val, cnt_val;
  logic flag, mod_load, wrap, step, frozen;
  logic [DATA_W-1:0] cs_rd;

  assign frozen = ctrl.frz_en && freeze_i;
  assign step   = ctrl.run && tick_i && !frozen;

  pit_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .sel_i, .wdata_i,
    .wrap_i(wrap), .ctrl_o(ctrl), .mod_o(mod_val),
    .flag_o(flag), .mod_load_o(mod_load)
  );

  pit_counter u_cnt (
    .clk_i, .rst_ni, .step_i(step), .load_i(mod_load),
    .load_val_i(wdata_i[CNT_W-1:0]), .mod_i(mod_val),
    .cnt_o(cnt_val), .wrap_o(wrap)
  );

  pit_irq_map u_map (
    .req_i(flag && ctrl.ie), .lvl_i(ctrl.lvl), .irq_o
  );

  always_comb begin
    cs_rd              = '0;
    cs_rd[LVL_W-1:0]   = ctrl.lvl;
    cs_rd[CS_RUN]      = ctrl.run;
    cs_rd[CS_IE]       = ctrl.ie;
    cs_rd[CS_FRZ]      = ctrl.frz_en;
    cs_rd[CS_FLAG]     = flag;
  end

  always_comb begin
    unique case (sel_e'(sel_i))
      SEL_MOD: rdata_o = DATA_W'(mod_val);
      SEL_CS:  rdata_o = cs_rd;
      SEL_CNT: rdata_o = DATA_W'(cnt_val);
      default: rdata_o = '0;
    endcase
  end

  a_r6_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> flag && ctrl.ie);
  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) && !(wr_i && sel_i == 2'd1) |=> $stable(irq_o));
  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen && !mod_load |=> $stable(cnt_val));
endmodule

// File: tb/sim_pit_timer.sv
module sim_pit_timer;
  localparam time CLK_PERIOD = 10;
  localparam int  MAX_CYC    = 200000;

  logic clk = 0, rst_n = 0, tick = 0, frz = 0, wr = 0;
  logic [1:0]  sel = 0;
  logic [15:0] wd = 0, rdata;
  logic [7:0]  irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [15:0] m_mod = 16'hFFFF, m_cnt = 16'hFFFF;
  logic [7:0]  m_lvl = 0;
  logic m_run = 0, m_ie = 0, m_frzc = 0, m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freeze_i(frz), .wr_i(wr),
    .sel_i(sel), .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] exp_cs();
    return {m_flag, 4'b0, m_frzc, m_ie, m_run, m_lvl};
  endfunction

  function automatic logic [7:0] exp_irq();
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = m_flag && m_ie && m_lvl[7-k];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] s, string tag, logic [15:0] exp);
    sel = s; wr = 0; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic check_all();
    chk("R6,R8 irq lines", irq, exp_irq());
    rd(2'd0, "R4,R9 modulus read", m_mod);
    rd(2'd1, "R5,R9 ctrl/status read", exp_cs());
    rd(2'd2, "R2,R3 counter read", m_cnt);
  endtask

  // drive one cycle (called just after a negedge), update model, check
  task automatic cyc(bit w, logic [1:0] s, logic [15:0] d, bit t, bit f);
    bit step, wrap;
    wr = w; sel = s; wd = d; tick = t; frz = f;
    step = m_run && t && !(m_frzc && f);
    wrap = step && (m_cnt == 0) && !(w && s == 2'd0);
    if (w && s == 2'd0) begin m_mod = d; m_cnt = d; end
    else if (wrap) m_cnt = m_mod;
    else if (step) m_cnt = m_cnt - 1;
    if (wrap) m_flag = 1;
    else if (w && s == 2'd1 && d[15]) m_flag = 0;
    if (w && s == 2'd1) begin
      m_lvl = d[7:0]; m_run = d[8]; m_ie = d[9]; m_frzc = d[10];
    end
    @(negedge clk);
    wr = 0; tick = 0; frz = 0;
    check_all();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq at reset", irq, 8'h00);
    rd(2'd0, "R1 modulus reset", 16'hFFFF);
    rd(2'd1, "R1 ctrl/status reset", 16'h0000);
    rd(2'd2, "R1 counter reset", 16'hFFFF);
    rd(2'd3, "R9 unused select", 16'h0000);
    rst_n = 1;
    @(negedge clk);

    // R2 ticks ignored while stopped, then counts
    cyc(0, 0, 0, 1, 0);
    rd(2'd2, "R2 hold while stopped", 16'hFFFF);
    cyc(1, 1, 16'h0100, 0, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    rd(2'd2, "R2 two decrements", 16'hFFFD);
    cyc(0, 0, 0, 0, 0);

    // R4 modulus write beats a tick
    cyc(1, 0, 16'd3, 1, 0);
    rd(2'd2, "R4 load on write", 16'd3);

    // R3 period = modulus+1
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0);
    rd(2'd1, "R3 no flag before wrap", 16'h0100);
    cyc(0, 0, 0, 1, 0);
    rd(2'd1, "R3 flag after wrap", 16'h8100);
    rd(2'd2, "R3 reload value", 16'd3);

    // R5 writing 0 keeps flag, set beats clear
    cyc(1, 1, 16'h0100, 0, 0);
    rd(2'd1, "R5 zero write no effect", 16'h8100);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0);
    cyc(1, 1, 16'h8100, 1, 0);
    rd(2'd1, "R5 set wins over clear", 16'h8100);
    cyc(1, 1, 16'h8100, 0, 0);
    rd(2'd1, "R5 clear by one", 16'h0100);

    // R6 request at level 0 via 0x80 (R8)
    cyc(1, 1, 16'h0380, 0, 0);
    chk("R6 no request without flag", irq, 8'h00);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0);
    chk("R8 level 0 from 0x80", irq, 8'h01);
    cyc(0, 0, 0, 0, 0);
    chk("R6 request held", irq, 8'h01);
    cyc(1, 1, 16'h0301, 0, 0);
    chk("R8 level 7 from 0x01", irq, 8'h80);
    cyc(1, 1, 16'h0101, 0, 0);
    chk("R6 gated by enable", irq, 8'h00);

    // R7 freeze control
    cyc(1, 0, 16'd10, 0, 0);
    cyc(1, 1, 16'h0580, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1);
    rd(2'd2, "R7 frozen counter holds", 16'd10);
    cyc(1, 1, 16'h0180, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1);
    rd(2'd2, "R7 freeze ignored when control 0", 16'd7);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit w;
      logic [1:0] s;
      logic [15:0] d;
      r = $urandom_range(0, 99);
      w = (r < 12);
      s = 2'($urandom_range(0, 3));
      d = 16'($urandom);
      if (w && s == 2'd0) d = 16'($urandom_range(0, 12));
      if (w && s == 2'd1) begin
        d[8] = ($urandom_range(0, 9) != 0);
        d[15] = ($urandom_range(0, 3) == 0);
        d[7:0] = 8'h1 << $urandom_range(0, 7);
      end
      cyc(w, s, d, $urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule